// File: doc/BRIEF.md
# Variable-Length Instruction Framer

This block sits between a byte fetch path and an instruction decoder for a 32-bit accumulator machine. Bytes arrive one at a time on a valid/ready handshake. The block works out where each instruction ends and presents one record per instruction. A record carries the opcode, the addressing class, the index qualifier, the operand byte count, the assembled operand and an invalid flag.

Framing takes two levels of decode. The first byte is an opcode, which an internal 256-entry classification (built from rules, not stored) maps to a mode. Immediate, indirect and absolute opcodes are followed by an attribute byte. For immediate instructions, the attribute byte chooses how many literal bytes follow. Relative branches carry a fixed two-byte signed offset.

A record stays on the output until the consumer accepts it. While a record is pending the input is stalled, so no byte is lost.

Top module: `instr_framer`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0 and in_ready is 1. Any partly received instruction is discarded, and the next accepted byte is treated as an opcode.
- R2: An implied-class opcode is a one-byte instruction. Its record has out_mode 0, out_size 0, out_value 0 and out_invalid 0.
- R3: An undefined opcode is a one-byte instruction. Its record has out_invalid 1, out_mode 0, out_index 0, out_size 0 and out_value 0.
- R4: A relative-class opcode (out_mode 1) is followed by two offset bytes, low byte first. The record has out_size 2, and out_value is that 16-bit offset sign-extended to 32 bits.
- R5: An immediate-class opcode (out_mode 2) is followed by an attribute byte. Bits [1:0] of that byte select the literal length: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. The literal is assembled little-endian and zero-extended into out_value, and out_size holds the byte count.
- R6: An immediate attribute whose bits [1:0] are 3 ends the instruction at the attribute byte. The record has out_invalid 1, out_mode 2, out_size 0 and out_value 0, and the following byte is a new opcode.
- R7: Indirect (out_mode 3) and absolute (out_mode 4) opcodes consume exactly one attribute byte. The record has out_size 0, and out_value is the attribute byte zero-extended.
- R8: out_index bit 0 marks X indexing and bit 1 marks Y indexing, as given by the opcode's classification.
- R9: While out_valid is 1 and out_ready is 0, every record field holds its value and in_ready is 0. No input byte is taken until the record is accepted.
- R10: Bits [7:2] of an immediate attribute byte have no effect on the literal length.
- R11: Opcodes are classified by high nibble h and low nibble l:
  - l=8 is implied for every h.
  - l=0 is:
    - implied for h = 0, 4 and 6;
    - absolute for h=2;
    - undefined for h=8;
    - relative for every other odd h;
    - immediate for h = A, C and E.
  - l=1 is indirect, with X for even h and Y for odd h.
  - l=2 is immediate only for h=A.
  - l=9 is:
    - absolute,Y for odd h;
    - undefined for h=8;
    - immediate for every other even h.
  - l=A is implied for h = 0, 2, 4, 6, 8, 9, A, B, C and E.
  - l=C is:
    - absolute for h = 2, 4, 8, A, C and E;
    - indirect for h=6;
    - absolute,X for h=B.
  - l=D is absolute for even h and absolute,X for odd h.
  - l=E is:
    - absolute for even h;
    - undefined for h=9;
    - absolute,Y for h=B;
    - absolute,X for every other odd h.
  - Everything else is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take a byte |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_mode | output | 3 | Class: 0 implied, 1 relative, 2 immediate, 3 indirect, 4 absolute |
| out_index | output | 2 | Bit 0 X indexing, bit 1 Y indexing |
| out_size | output | CNT_W (3) | Operand bytes after the opcode or attribute |
| out_value | output | VAL_W (32) | Assembled operand |
| out_invalid | output | 1 | Undefined opcode or illegal attribute |

## Verification
The bench sweeps all 256 opcodes. For each one it feeds exactly the byte count the classification rules call for, and it puts noise in the upper attribute bits and uses offsets of both signs.

A wrong classification entry would desynchronise every later instruction. A sign-extension slip would show as a positive value for a negative branch offset. A byte-order mistake would swap literal bytes.

Three corner cases get dedicated checks:
- An illegal size code: a design that consumed a literal after it would swallow the next opcode.
- A record held back by the consumer: a design that kept in_ready high would drop or overwrite bytes.
- A reset in the middle of a literal: a design that kept partial state would treat the next opcode as operand data.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

    // classification bit set produced by the opcode lookup
    localparam logic [7:0] MB_IMPL  = 8'h00;
    localparam logic [7:0] MB_REL   = 8'h01;
    localparam logic [7:0] MB_IMM   = 8'h02;
    localparam logic [7:0] MB_IND   = 8'h04;
    localparam logic [7:0] MB_ABS   = 8'h08;
    localparam logic [7:0] MB_X     = 8'h10;
    localparam logic [7:0] MB_Y     = 8'h20;
    localparam logic [7:0] MB_UNDEF = 8'hFF;

    typedef enum logic [2:0] {
        CLS_IMPL = 3'd0,
        CLS_REL  = 3'd1,
        CLS_IMM  = 3'd2,
        CLS_IND  = 3'd3,
        CLS_ABS  = 3'd4
    } mode_cls_e;

    typedef enum logic [1:0] {
        ST_OPC  = 2'd0,
        ST_ATTR = 2'd1,
        ST_BODY = 2'd2,
        ST_HOLD = 2'd3
    } fr_state_e;

endpackage

// File: rtl/ifr_mode_lut.sv
module ifr_mode_lut
    import ifr_pkg::*;
(
    input  logic [7:0] opcode_i,
    output logic [7:0] mode_o
);

    logic [3:0] row;
    logic [3:0] col;
    logic       odd;

    assign row = opcode_i[7:4];
    assign col = opcode_i[3:0];
    assign odd = opcode_i[4];

    always_comb begin
        mode_o = MB_UNDEF;
        unique case (col)
            4'h0: begin
                if (row == 4'h8)                       mode_o = MB_UNDEF;
                else if (row == 4'h2)                  mode_o = MB_ABS;
                else if (odd)                          mode_o = MB_REL;
                else if (row >= 4'hA)                  mode_o = MB_IMM;
                else                                   mode_o = MB_IMPL;
            end
            4'h1: mode_o = MB_IND | (odd ? MB_Y : MB_X);
            4'h2: mode_o = (row == 4'hA) ? MB_IMM : MB_UNDEF;
            4'h8: mode_o = MB_IMPL;
            4'h9: begin
                if (odd)                               mode_o = MB_ABS | MB_Y;
                else if (row == 4'h8)                  mode_o = MB_UNDEF;
                else                                   mode_o = MB_IMM;
            end
            4'hA: begin
                if (!odd && row != 4'hC && row != 4'hE && row < 4'h8) mode_o = MB_IMPL;
                else if (row >= 4'h8 && row <= 4'hC)   mode_o = MB_IMPL;
                else if (row == 4'hE)                  mode_o = MB_IMPL;
                else                                   mode_o = MB_UNDEF;
            end
            4'hC: begin
                unique case (row)
                    4'h2, 4'h4, 4'h8,
                    4'hA, 4'hC, 4'hE:                  mode_o = MB_ABS;
                    4'h6:                              mode_o = MB_IND;
                    4'hB:                              mode_o = MB_ABS | MB_X;
                    default:                           mode_o = MB_UNDEF;
                endcase
            end
            4'hD: mode_o = odd ? (MB_ABS | MB_X) : MB_ABS;
            4'hE: begin
                if (!odd)                              mode_o = MB_ABS;
                else if (row == 4'h9)                  mode_o = MB_UNDEF;
                else if (row == 4'hB)                  mode_o = MB_ABS | MB_Y;
                else                                   mode_o = MB_ABS | MB_X;
            end
            default: mode_o = MB_UNDEF;
        endcase
    end

endmodule

// File: rtl/ifr_byte_merge.sv
module ifr_byte_merge #(
    parameter int VAL_W = 32,
    parameter int POS_W = 3
) (
    input  logic [VAL_W-1:0] acc_i,
    input  logic [7:0]       byte_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             sext_i,
    output logic [VAL_W-1:0] val_o
);

    logic [VAL_W-1:0] placed;
    logic [VAL_W-1:0] low_mask;

    always_comb begin
        placed   = VAL_W'(byte_i) << (8 * 32'(pos_i));
        low_mask = (VAL_W'(1) << (8 * (32'(pos_i) + 1))) - VAL_W'(1);
        val_o    = acc_i | placed;
        if (sext_i && byte_i[7]) begin
            val_o = val_o | ~low_mask;
        end
    end

endmodule

// File: rtl/instr_framer.sv
module instr_framer
    import ifr_pkg::*;
#(
    parameter int VAL_W = 32,
    localparam int MAX_BYTES = VAL_W / 8,
    localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_opcode,
    output logic [2:0]       out_mode,
    output logic [1:0]       out_index,
    output logic [CNT_W-1:0] out_size,
    output logic [VAL_W-1:0] out_value,
    output logic             out_invalid
);

    typedef struct packed {
        fr_state_e        st;
        logic [7:0]       opc;
        mode_cls_e        cls;
        logic [1:0]       idx;
        logic [CNT_W-1:0] size;
        logic [CNT_W-1:0] left;
        logic [CNT_W-1:0] pos;
        logic [VAL_W-1:0] val;
        logic             bad;
    } fr_regs_t;

    fr_regs_t         r_q;
    fr_regs_t         r_d;
    logic [7:0]       mode_bits;
    logic [VAL_W-1:0] merged;
    logic             take;
    logic             give;
    logic             sext_now;

    ifr_mode_lut u_lut (
        .opcode_i (in_data),
        .mode_o   (mode_bits)
    );

    assign sext_now = (r_q.cls == CLS_REL) && (r_q.left == CNT_W'(1));

    ifr_byte_merge #(.VAL_W(VAL_W), .POS_W(CNT_W)) u_merge (
        .acc_i  (r_q.val),
        .byte_i (in_data),
        .pos_i  (r_q.pos),
        .sext_i (sext_now),
        .val_o  (merged)
    );

    assign in_ready    = (r_q.st != ST_HOLD);
    assign out_valid   = (r_q.st == ST_HOLD);
    assign take        = in_valid && in_ready;
    assign give        = out_valid && out_ready;
    assign out_opcode  = r_q.opc;
    assign out_mode    = r_q.cls;
    assign out_index   = r_q.idx;
    assign out_size    = r_q.size;
    assign out_value   = r_q.val;
    assign out_invalid = r_q.bad;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_OPC: begin
                if (take) begin
                    r_d.opc  = in_data;
                    r_d.val  = '0;
                    r_d.pos  = '0;
                    r_d.size = '0;
                    r_d.left = '0;
                    r_d.bad  = 1'b0;
                    r_d.idx  = {mode_bits[5], mode_bits[4]};
                    if (mode_bits == MB_UNDEF) begin
                        r_d.bad = 1'b1;
                        r_d.cls = CLS_IMPL;
                        r_d.idx = 2'b00;
                        r_d.st  = ST_HOLD;
                    end else if (mode_bits[0]) begin
                        r_d.cls  = CLS_REL;
                        r_d.size = CNT_W'(2);
                        r_d.left = CNT_W'(2);
                        r_d.st   = ST_BODY;
                    end else if (mode_bits[1]) begin
                        r_d.cls = CLS_IMM;
                        r_d.st  = ST_ATTR;
                    end else if (mode_bits[2]) begin
                        r_d.cls = CLS_IND;
                        r_d.st  = ST_ATTR;
                    end else if (mode_bits[3]) begin
                        r_d.cls = CLS_ABS;
                        r_d.st  = ST_ATTR;
                    end else begin
                        r_d.cls = CLS_IMPL;
                        r_d.st  = ST_HOLD;
                    end
                end
            end
            ST_ATTR: begin
                if (take) begin
                    if (r_q.cls == CLS_IMM) begin
                        unique case (in_data[1:0])
                            2'd0: begin r_d.size = CNT_W'(1); r_d.st = ST_BODY; end
                            2'd1: begin r_d.size = CNT_W'(2); r_d.st = ST_BODY; end
                            2'd2: begin r_d.size = CNT_W'(4); r_d.st = ST_BODY; end
                            default: begin
                                r_d.size = '0;
                                r_d.bad  = 1'b1;
                                r_d.st   = ST_HOLD;
                            end
                        endcase
                        r_d.left = r_d.size;
                    end else begin
                        r_d.val = VAL_W'(in_data);
                        r_d.st  = ST_HOLD;
                    end
                end
            end
            ST_BODY: begin
                if (take) begin
                    r_d.val  = merged;
                    r_d.pos  = r_q.pos + CNT_W'(1);
                    r_d.left = r_q.left - CNT_W'(1);
                    if (r_q.left == CNT_W'(1)) begin
                        r_d.st = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (give) begin
                    r_d.st = ST_OPC;
                end
            end
            default: r_d.st = ST_OPC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R1: leaving reset the framer is empty and waiting
    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!out_valid && in_ready));

    // R9: a pending record does not move and blocks input
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && !in_ready
            && $stable(out_opcode) && $stable(out_value) && $stable(out_size)
            && $stable(out_mode) && $stable(out_index) && $stable(out_invalid)));

    // R4: relative offset is two bytes, sign-extended
    assert_rel_sext_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == CLS_REL) |->
            (out_size == CNT_W'(2) && out_value[VAL_W-1:16] == {(VAL_W-16){out_value[15]}}));

    // R5: a legal immediate reports 1, 2 or 4 bytes
    assert_imm_size_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == CLS_IMM && !out_invalid) |->
            (out_size == CNT_W'(1) || out_size == CNT_W'(2) || out_size == CNT_W'(4)));

    // R3 / R6: an invalid record carries no operand
    assert_bad_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_invalid) |-> (out_size == '0 && out_value == '0));

    // R7: absolute and indirect hold only the attribute byte
    assert_attr_only_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_mode == CLS_ABS || out_mode == CLS_IND)) |->
            (out_size == '0 && out_value[VAL_W-1:8] == '0));

endmodule

// File: tb/tb_instr_framer.sv
`timescale 1ns/1ps
module tb_instr_framer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic [2:0]  out_mode;
    logic [1:0]  out_index;
    logic [2:0]  out_size;
    logic [31:0] out_value;
    logic        out_invalid;

    int tests = 0;
    int fails = 0;

    logic [7:0]  c_opc;
    logic [2:0]  c_mode;
    logic [1:0]  c_idx;
    logic [2:0]  c_size;
    logic [31:0] c_val;
    logic        c_bad;

    always #5 clk = ~clk;

    instr_framer dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_mode(out_mode), .out_index(out_index),
        .out_size(out_size), .out_value(out_value), .out_invalid(out_invalid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic pop(input string tag);
        int n;
        n = 0;
        @(negedge clk);
        while (!out_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        check({tag, " record present"}, 32'(out_valid), 32'd1);
        c_opc = out_opcode; c_mode = out_mode; c_idx = out_index;
        c_size = out_size;  c_val = out_value; c_bad = out_invalid;
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    // classification from R11: {class, index, undefined}
    function automatic logic [5:0] ref_cls(input logic [7:0] op);
        logic [3:0] h, l;
        logic [2:0] c;
        logic [1:0] x;
        logic u;
        h = op[7:4]; l = op[3:0]; c = 3'd0; x = 2'b00; u = 1'b0;
        case (l)
            4'h0: if (h == 4'h0 || h == 4'h4 || h == 4'h6) c = 3'd0;
                  else if (h == 4'h2) c = 3'd4;
                  else if (h == 4'h8) u = 1'b1;
                  else if (h[0]) c = 3'd1;
                  else c = 3'd2;
            4'h1: begin c = 3'd3; x = h[0] ? 2'b10 : 2'b01; end
            4'h2: if (h == 4'hA) c = 3'd2; else u = 1'b1;
            4'h8: c = 3'd0;
            4'h9: if (h[0]) begin c = 3'd4; x = 2'b10; end
                  else if (h == 4'h8) u = 1'b1;
                  else c = 3'd2;
            4'hA: if (h inside {4'h0, 4'h2, 4'h4, 4'h6, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hE}) c = 3'd0;
                  else u = 1'b1;
            4'hC: if (h inside {4'h2, 4'h4, 4'h8, 4'hA, 4'hC, 4'hE}) c = 3'd4;
                  else if (h == 4'h6) c = 3'd3;
                  else if (h == 4'hB) begin c = 3'd4; x = 2'b01; end
                  else u = 1'b1;
            4'hD: begin c = 3'd4; x = h[0] ? 2'b01 : 2'b00; end
            4'hE: if (!h[0]) c = 3'd4;
                  else if (h == 4'h9) u = 1'b1;
                  else if (h == 4'hB) begin c = 3'd4; x = 2'b10; end
                  else begin c = 3'd4; x = 2'b01; end
            default: u = 1'b1;
        endcase
        if (u) begin c = 3'd0; x = 2'b00; end
        return {c, x, u};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 reset out_valid", 32'(out_valid), 32'd0);
        check("R1 reset in_ready", 32'(in_ready), 32'd1);

        // exhaustive opcode sweep: R2 R3 R4 R5 R7 R8 R10 R11
        for (int op = 0; op < 256; op++) begin
            logic [5:0]  m;
            logic [7:0]  b8, attr, lo, hi;
            logic [2:0]  es;
            logic [31:0] ev;
            string       tg;
            b8 = 8'(op);
            m  = ref_cls(b8);
            es = 3'd0; ev = 32'd0;
            push(b8);
            if (m[0]) tg = "R3";
            else case (m[5:3])
                3'd0: tg = "R2";
                3'd1: begin
                    tg = "R4";
                    lo = b8; hi = b8 ^ 8'hA5;
                    push(lo); push(hi);
                    es = 3'd2; ev = {{16{hi[7]}}, hi, lo};
                end
                3'd2: begin
                    tg = "R5";
                    attr = (b8 & 8'hFC) | 8'(op % 3);
                    push(attr);
                    es = 3'(1 << (op % 3));
                    for (int k = 0; k < int'(es); k++) begin
                        logic [7:0] lb;
                        lb = 8'(op + 37 * k + 1);
                        push(lb);
                        ev = ev | (32'(lb) << (8 * k));
                    end
                end
                default: begin
                    tg = "R7";
                    attr = ~b8;
                    push(attr);
                    ev = 32'(attr);
                end
            endcase
            pop(tg);
            check("R11 opcode", 32'(c_opc), 32'(b8));
            check("R11 mode", 32'(c_mode), 32'(m[5:3]));
            check("R8 index", 32'(c_idx), 32'(m[2:1]));
            check((m[5:3] == 3'd2 && !m[0]) ? "R10 size" : {tg, " size"}, 32'(c_size), 32'(es));
            check({tg, " value"}, c_val, ev);
            check({tg, " invalid"}, 32'(c_bad), 32'(m[0]));
        end

        // R6: illegal size code, then a fresh opcode
        push(8'hA9); push(8'h07);
        pop("R6");
        check("R6 invalid", 32'(c_bad), 32'd1);
        check("R6 mode", 32'(c_mode), 32'd2);
        check("R6 size", 32'(c_size), 32'd0);
        check("R6 value", c_val, 32'd0);
        push(8'h18);
        pop("R6 next");
        check("R6 next opcode", 32'(c_opc), 32'h18);
        check("R6 next invalid", 32'(c_bad), 32'd0);

        // R9: record held while consumer stalls, input blocked
        push(8'h08);
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h38;
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            check("R9 in_ready low", 32'(in_ready), 32'd0);
            check("R9 held opcode", 32'(out_opcode), 32'h08);
            check("R9 held valid", 32'(out_valid), 32'd1);
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
        @(posedge clk);
        #1 in_valid = 1'b0;
        pop("R9 next");
        check("R9 queued byte taken", 32'(c_opc), 32'h38);
        check("R9 queued byte mode", 32'(c_mode), 32'd0);

        // R1: reset in the middle of a 4-byte literal
        push(8'h09); push(8'h02); push(8'h55);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 mid reset out_valid", 32'(out_valid), 32'd0);
        check("R1 mid reset in_ready", 32'(in_ready), 32'd1);
        push(8'hEA);
        pop("R1 after reset");
        check("R1 opcode after reset", 32'(c_opc), 32'hEA);
        check("R1 mode after reset", 32'(c_mode), 32'd0);
        check("R1 size after reset", 32'(c_size), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule